// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The engine walks a ring of four-word transmit descriptors held in a small local descriptor RAM. The host fills descriptors through a simple word port and hands each one to the engine by setting its ownership flag. On a transmit-demand pulse or a periodic poll tick, the engine looks at the current descriptor. If the engine owns it, the engine offers the buffer address and byte count on a request/done send interface. When the send completes, it stores the returned status, hands the descriptor back to the host and pulses a done event. It then moves to the next slot and repeats until it meets a descriptor that the host still owns.

Descriptor i occupies RAM words 4i to 4i+3:
- Word 0 holds address bits 15:0.
- Word 1 holds the flag byte in bits 15:8 and address bits 23:16 in bits 7:0.
- Word 2 holds the negated byte count.
- Word 3 holds the completion status.

Flag bit 7 is ownership, with 1 meaning the engine owns the descriptor. The other flag bits are:
- bit 6: error summary
- bit 4: more than one retry
- bit 3: exactly one retry
- bit 2: deferred
- bit 1: start of packet
- bit 0: end of packet

The ring holds 2^n entries, where n is the 3-bit ring-size code. Codes above the parameter MAX_LOG are treated as MAX_LOG. The host must pad short frames itself, because the engine sends exactly the stated count.

Top module: `txring_engine`

## Requirements
- R1: After reset, send_req and tx_done are low, and the first descriptor examined is slot 0.
- R2: A tx_demand or poll_tick pulse makes the engine examine the current descriptor. If flag bit 7 (word 1 bit 15) is 1, the engine raises send_req with send_addr = {word1[7:0], word0}.
- R3: send_len is the low 12 bits of the two's complement of word 2. For example, 0xFFC4 gives 60 and 0xFA16 gives 1514.
- R4: A descriptor whose ownership bit is 0 produces no send_req. The engine stays on that slot and serves it on a later demand or poll pulse once the host sets the ownership bit.
- R5: On completion, the engine writes word 3 with send_status unchanged. It then writes word 1 with the ownership bit cleared, the address byte unchanged, and flag bits 0, 1 and 5 kept.
- R6: In the written flag byte, bit 6 is 1 exactly when any of status bits 15:10 is set. Bits 2, 3 and 4 take done_deferred, done_one_retry and done_multi_retry.
- R7: tx_done is a one-cycle pulse for each completed descriptor. It follows the ownership write, so a host read made after it sees the ownership bit at 0.
- R8: After slot 2^n-1 the engine continues at slot 0. It keeps walking owned descriptors without a further demand pulse.
- R9: While send_req is high and send_done is low, send_req, send_addr and send_len stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ring_log | input | 3 | Ring-size code n; the ring holds 2^n entries |
| tx_demand | input | 1 | Immediate poll request pulse |
| poll_tick | input | 1 | Periodic poll pulse |
| host_we | input | 1 | Host write strobe |
| host_addr | input | MAX_LOG+2 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after the address |
| send_req | output | 1 | Frame send request |
| send_addr | output | 24 | Buffer address |
| send_len | output | 12 | Byte count |
| send_done | input | 1 | Send completion pulse |
| send_status | input | 16 | Completion status word |
| done_one_retry | input | 1 | The send needed one retry |
| done_multi_retry | input | 1 | The send needed more than one retry |
| done_deferred | input | 1 | The send was deferred |
| tx_done | output | 1 | Descriptor completed pulse |

## Verification
The bench serves several kinds of descriptor:
- A clean short frame with a deferral. This shows that the flags are merged and preserved rather than overwritten.
- A full-size frame with lost-carrier and retry-failure status. This shows that the error summary follows the status bits.
- A frame whose status carries only a reflectometry count. This shows that the low status bits do not set the summary.

A slot that the host still owns separates stopping and resuming from blind advancing. A burst across the last slot of a four-entry ring confirms the wrap, and that the walk continues without a new demand.

// File: rtl/txring_engine.sv
module txring_engine #(
  parameter int MAX_LOG = 3,
  localparam int IW = MAX_LOG,
  localparam int AW = MAX_LOG + 2,
  localparam int DEPTH = 4 << MAX_LOG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    ring_log,
  input  logic          tx_demand,
  input  logic          poll_tick,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata,
  output logic          send_req,
  output logic [23:0]   send_addr,
  output logic [11:0]   send_len,
  input  logic          send_done,
  input  logic [15:0]   send_status,
  input  logic          done_one_retry,
  input  logic          done_multi_retry,
  input  logic          done_deferred,
  output logic          tx_done
);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_SEND, S_WSTAT, S_WOWN} state_t;

  state_t        state;
  logic [15:0]   mem [0:DEPTH-1];
  logic [IW-1:0] idx;
  logic [15:0]   st_q;
  logic [2:0]    rflags_q;

  logic [2:0]    n_eff;
  logic [IW-1:0] ring_mask;
  logic [IW-1:0] pidx;

  assign n_eff     = (ring_log > 3'(MAX_LOG)) ? 3'(MAX_LOG) : ring_log;
  assign ring_mask = IW'((32'd1 << n_eff) - 32'd1);
  assign pidx      = (idx - 1'b1) & ring_mask;
  assign send_req  = (state == S_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      send_addr <= '0;
      send_len  <= '0;
      st_q      <= '0;
      rflags_q  <= '0;
      tx_done   <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      case (state)
        S_IDLE:  if (tx_demand || poll_tick) state <= S_CHECK;
        S_CHECK: begin
          if (mem[{idx, 2'd1}][15]) begin
            send_addr <= {mem[{idx, 2'd1}][7:0], mem[{idx, 2'd0}]};
            send_len  <= 12'(~mem[{idx, 2'd2}] + 16'd1);
            state     <= S_SEND;
          end else begin
            state <= S_IDLE;
          end
        end
        S_SEND: if (send_done) begin
          st_q     <= send_status;
          rflags_q <= {done_multi_retry, done_one_retry, done_deferred};
          state    <= S_WSTAT;
        end
        S_WSTAT: state <= S_WOWN;
        S_WOWN: begin
          idx     <= (idx + 1'b1) & ring_mask;
          tx_done <= 1'b1;
          state   <= S_CHECK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_WSTAT)
      mem[{idx, 2'd3}] <= st_q;
    if (state == S_WOWN)
      mem[{idx, 2'd1}] <= {1'b0, |st_q[15:10], mem[{idx, 2'd1}][13], rflags_q,
                           mem[{idx, 2'd1}][9:8], mem[{idx, 2'd1}][7:0]};
    if (host_we)
      mem[host_addr] <= host_wdata;
    host_rdata <= mem[host_addr];
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (send_req && !send_done) |=> (send_req && $stable(send_addr) && $stable(send_len))); // R9

  AST_OWN_AT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_req) |-> mem[{idx, 2'd1}][15]); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done); // R7

  AST_DONE_WB: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!mem[{pidx, 2'd1}][15] &&
                 (mem[{pidx, 2'd1}][14] == |mem[{pidx, 2'd3}][15:10]))); // R6

endmodule

// File: tb/sim_txring_engine.sv
module sim_txring_engine;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] ring_log = 3'd2;
  logic tx_demand = 1'b0, poll_tick = 1'b0;
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic send_req;
  logic [23:0] send_addr;
  logic [11:0] send_len;
  logic send_done = 1'b0;
  logic [15:0] send_status = '0;
  logic done_one_retry = 1'b0, done_multi_retry = 1'b0, done_deferred = 1'b0;
  logic tx_done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  txring_engine #(.MAX_LOG(3)) u0 (
    .clk(clk), .rst_n(rst_n), .ring_log(ring_log), .tx_demand(tx_demand),
    .poll_tick(poll_tick), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .send_req(send_req),
    .send_addr(send_addr), .send_len(send_len), .send_done(send_done),
    .send_status(send_status), .done_one_retry(done_one_retry),
    .done_multi_retry(done_multi_retry), .done_deferred(done_deferred),
    .tx_done(tx_done));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !finished) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic write_desc(input int i, input logic [23:0] a, input int len, input bit own);
    hwrite(AW'(4*i), a[15:0]);
    hwrite(AW'(4*i+2), 16'(16'h0 - 16'(len)) | 16'hF000);
    hwrite(AW'(4*i+3), 16'h0);
    hwrite(AW'(4*i+1), {own ? 8'h83 : 8'h03, a[23:16]});
  endtask

  task automatic pulse_demand(input bit tick);
    @(negedge clk);
    if (tick) poll_tick = 1'b1; else tx_demand = 1'b1;
    @(negedge clk);
    poll_tick = 1'b0; tx_demand = 1'b0;
  endtask

  task automatic serve(input logic [23:0] ea, input logic [11:0] el, input logic [15:0] st,
                       input bit one, input bit more, input bit def, input string tag);
    int n;
    n = 0;
    while (!send_req && n < 300) begin @(negedge clk); n++; end
    chk(send_req, {tag, " R2 request"}, 32'(send_req), 1);
    chk(send_addr == ea, {tag, " R2 address"}, 32'(send_addr), 32'(ea));
    chk(send_len == el, {tag, " R3 length"}, 32'(send_len), 32'(el));
    repeat (3) begin
      @(negedge clk);
      chk(send_req && send_addr == ea && send_len == el, {tag, " R9 hold"},
          {7'd0, send_req, send_addr}, {8'd1, ea});
    end
    send_status = st; done_one_retry = one; done_multi_retry = more; done_deferred = def;
    send_done = 1'b1;
    @(negedge clk);
    send_done = 1'b0;
    n = 0;
    while (!tx_done && n < 20) begin @(negedge clk); n++; end
    chk(tx_done, {tag, " R7 done"}, 32'(tx_done), 1);
    @(negedge clk);
    chk(!tx_done, {tag, " R7 single pulse"}, 32'(tx_done), 0);
  endtask

  task automatic check_wb(input int i, input logic [15:0] w1, input logic [15:0] w3, input string tag);
    logic [15:0] d;
    hread(AW'(4*i+3), d);
    chk(d == w3, {tag, " R5 status word"}, 32'(d), 32'(w3));
    hread(AW'(4*i+1), d);
    chk(d == w1, {tag, " R5 R6 flag word"}, 32'(d), 32'(w1));
  endtask

  task automatic t_reset;
    chk(!send_req, "R1 send_req at reset", 32'(send_req), 0);
    chk(!tx_done, "R1 tx_done at reset", 32'(tx_done), 0);
  endtask

  task automatic t_basic;
    write_desc(0, 24'h123456, 60, 1);
    pulse_demand(0);
    serve(24'h123456, 12'd60, 16'h0000, 0, 0, 1, "R1 slot0");
    check_wb(0, 16'h0712, 16'h0000, "basic");
  endtask

  task automatic t_error;
    write_desc(1, 24'hA0BEEF, 1514, 1);
    pulse_demand(0);
    serve(24'hA0BEEF, 12'd1514, 16'h0C05, 1, 0, 0, "error");
    check_wb(1, 16'h4BA0, 16'h0C05, "error");
  endtask

  task automatic t_stop;
    bit seen;
    write_desc(2, 24'h00C0DE, 128, 0);
    pulse_demand(0);
    seen = 0;
    repeat (20) begin @(negedge clk); if (send_req) seen = 1; end
    chk(!seen, "R4 no request for host-owned slot", 32'(seen), 0);
    hwrite(AW'(9), 16'h8300);
    pulse_demand(1);
    serve(24'h00C0DE, 12'd128, 16'h0005, 0, 1, 0, "R4 resume");
    check_wb(2, 16'h1300, 16'h0005, "tdr only");
  endtask

  task automatic t_wrap;
    write_desc(3, 24'h333333, 64, 1);
    write_desc(0, 24'h444444, 100, 1);
    pulse_demand(0);
    serve(24'h333333, 12'd64, 16'h8000, 0, 0, 0, "R8 last slot");
    serve(24'h444444, 12'd100, 16'h1000, 0, 0, 0, "R8 wrapped slot0");
    check_wb(3, 16'h4333, 16'h8000, "wrap3");
    check_wb(0, 16'h4344, 16'h1000, "wrap0");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) hwrite(AW'(4*i+1), 16'h0000);
    t_basic();
    t_error();
    t_stop();
    t_wrap();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule